// File: doc/BRIEF.md
# Two-Level Instruction Decoder

This block turns a 32-bit instruction word of a RISC-style core into a compact decode record. It looks at the major opcode in bits 31..26 first. Most major opcodes resolve directly to an internal operation code. Three major opcodes carry a minor field and are decoded further by a second-level table. Each of those tables is indexed straight from instruction bits, with no intermediate enumeration.

The sparse minor space of major opcode 19 is handled in two parts. A 1024-bit legality bitmap is indexed by the full minor field in bits 10..1. A separate 8-entry table, indexed by bits 5, 3 and 2, supplies the operation. The rotate space of major opcode 30 is handled by a 3-bit index. Variants that differ only in one bit (link versus count target, mask type, single-field condition moves) share one operation code. Special-register moves also share one code per direction. The instruction word is passed through unchanged, so that the execute stage can resolve these variants from the raw bits.

The record is registered. It is updated on every cycle that presents a valid word, and it holds its value otherwise.

Top module: `insn_decode_2lvl`

## Requirements
- R1: While `rst` is high, and after it, until the first valid input: `out_valid`=0, `out_op`=1 (NOP), `out_illegal`=0, `out_insn`=0, `out_gpr_deps`=0.
- R2: A word presented with `in_valid`=1 at a rising edge appears in the record after that edge. `out_valid` is high for exactly those cycles. With `in_valid`=0 the record (`out_op`, `out_illegal`, `out_insn`, `out_gpr_deps`) keeps its value and `out_valid` is 0.
- R3: Major-level codes are as follows. 14→2, 15→3, 24→4, 18→5, 16→6, 32→23, 36→24. Majors 19, 30 and 31 use second-level tables. Every other major is illegal.
- R4: The exact word 0x60000000 decodes to NOP (1) with `out_gpr_deps`=0. Any other major-24 word decodes to 4.
- R5: For major 19, only minor codes (bits 10..1) 0, 16, 33, 129, 150, 193, 225, 257, 289, 417, 449, 528 and 560 are legal. Any other minor is illegal, even when its 3-bit column holds a valid entry.
- R6: For legal major-19 words, the index {bit5,bit3,bit2} selects the operation: 0→8 (condition-field operations), 4→7 (branch to register, for minors 16, 528 and 560 alike), 7→9 (sync). Other columns are illegal.
- R7: For major 30, the index bits 4..2 select: 0→10, 1→11, 2→12, 3→13, 4→14. Bit 1 does not affect the result. Indexes 5 to 7 are illegal.
- R8: For major 31, the minor field in bits 10..1 maps as follows: 266→15, 444→16, 28→17, 19→18, 144→19, 339→20, 467→21, 4→22. Every other minor is illegal.
- R9: Major-31 minors 19 and 144 decode to the same code whatever the value of bit 20.
- R10: Major-31 minors 339 and 467 decode to 20 and 21 whatever the value of the register-number field in bits 20..11.
- R11: An illegal word gives `out_illegal`=1, `out_op`=0 and `out_gpr_deps`=0, and passes `out_insn` through unchanged. `out_illegal` is 1 exactly when `out_op` is 0.
- R12: `out_gpr_deps` is 0 for codes 0, 1, 5, 6, 7, 8 and 9, and 1 for all others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word is valid this cycle |
| in_insn | input | 32 | Instruction word |
| out_valid | output | 1 | Record was updated at the last edge |
| out_op | output | 6 | Internal operation code |
| out_illegal | output | 1 | Word is not a legal encoding |
| out_insn | output | 32 | Instruction word passed through |
| out_gpr_deps | output | 1 | Operation touches general registers |

## Verification
The vector table covers every major-level entry and every legal major-19 minor. It also includes major-19 minors that fall in a valid column but are cleared in the bitmap, which separates the bitmap check from the column lookup. Pairs of words that differ only in bit 1, bit 10, bit 20 or the register-number field confirm that each pair shares one code. The word 0x60000000 is compared against a neighbouring ori word, to show the no-op entry. Directed tests then drop `in_valid` while the input word changes, to show that the record holds, and apply reset in the middle of the run.

// File: rtl/insn_decode_2lvl.sv
module insn_decode_2lvl #(
  parameter int OPW = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [31:0]    in_insn,
  output logic           out_valid,
  output logic [OPW-1:0] out_op,
  output logic           out_illegal,
  output logic [31:0]    out_insn,
  output logic           out_gpr_deps
);

  localparam logic [OPW-1:0] OP_ILL    = 0;
  localparam logic [OPW-1:0] OP_NOP    = 1;
  localparam logic [OPW-1:0] OP_ADDI   = 2;
  localparam logic [OPW-1:0] OP_ADDIS  = 3;
  localparam logic [OPW-1:0] OP_ORI    = 4;
  localparam logic [OPW-1:0] OP_BR     = 5;
  localparam logic [OPW-1:0] OP_BCOND  = 6;
  localparam logic [OPW-1:0] OP_BCREG  = 7;
  localparam logic [OPW-1:0] OP_CRFLD  = 8;
  localparam logic [OPW-1:0] OP_SYNC   = 9;
  localparam logic [OPW-1:0] OP_ROTL0  = 10;
  localparam logic [OPW-1:0] OP_ROTR0  = 11;
  localparam logic [OPW-1:0] OP_ROTC   = 12;
  localparam logic [OPW-1:0] OP_ROTINS = 13;
  localparam logic [OPW-1:0] OP_ROTREG = 14;
  localparam logic [OPW-1:0] OP_ADD    = 15;
  localparam logic [OPW-1:0] OP_OR     = 16;
  localparam logic [OPW-1:0] OP_AND    = 17;
  localparam logic [OPW-1:0] OP_MFCOND = 18;
  localparam logic [OPW-1:0] OP_MTCOND = 19;
  localparam logic [OPW-1:0] OP_MFSPEC = 20;
  localparam logic [OPW-1:0] OP_MTSPEC = 21;
  localparam logic [OPW-1:0] OP_TRAP   = 22;
  localparam logic [OPW-1:0] OP_LOAD   = 23;
  localparam logic [OPW-1:0] OP_STORE  = 24;

  localparam int MINW = 10;
  localparam int MINN = 1 << MINW;
  localparam logic [31:0] NOP_WORD = 32'h6000_0000;

  // Legality bitmap for the sparse major-19 space (R5)
  function automatic logic [MINN-1:0] build_legal19();
    logic [MINN-1:0] m;
    m = '0;
    for (int i = 0; i < MINN; i++) begin
      case (i)
        0, 16, 33, 129, 150, 193, 225, 257,
        289, 417, 449, 528, 560: m[i] = 1'b1;
        default:                 m[i] = 1'b0;
      endcase
    end
    return m;
  endfunction

  localparam logic [MINN-1:0] LEGAL19 = build_legal19();

  logic [5:0]      major;
  logic [MINW-1:0] minor;
  logic [2:0]      col19;
  logic [2:0]      idx30;
  logic [OPW-1:0]  op19, op30, op31, op_main, op_next;
  logic            deps_next;

  assign major = in_insn[31:26];
  assign minor = in_insn[10:1];
  assign col19 = {in_insn[5], in_insn[3], in_insn[2]};
  assign idx30 = in_insn[4:2];

  // Major-19 column table (R6)
  always_comb begin
    case (col19)
      3'd0:    op19 = OP_CRFLD;
      3'd4:    op19 = OP_BCREG;
      3'd7:    op19 = OP_SYNC;
      default: op19 = OP_ILL;
    endcase
    if (!LEGAL19[minor]) op19 = OP_ILL;
  end

  // Major-30 rotate table, bit 1 left to execute (R7)
  always_comb begin
    case (idx30)
      3'd0:    op30 = OP_ROTL0;
      3'd1:    op30 = OP_ROTR0;
      3'd2:    op30 = OP_ROTC;
      3'd3:    op30 = OP_ROTINS;
      3'd4:    op30 = OP_ROTREG;
      default: op30 = OP_ILL;
    endcase
  end

  // Major-31 table indexed by the raw minor field (R8, R9, R10)
  always_comb begin
    case (minor)
      10'd266: op31 = OP_ADD;
      10'd444: op31 = OP_OR;
      10'd28:  op31 = OP_AND;
      10'd19:  op31 = OP_MFCOND;
      10'd144: op31 = OP_MTCOND;
      10'd339: op31 = OP_MFSPEC;
      10'd467: op31 = OP_MTSPEC;
      10'd4:   op31 = OP_TRAP;
      default: op31 = OP_ILL;
    endcase
  end

  // First level (R3, R4)
  always_comb begin
    case (major)
      6'd14:   op_main = OP_ADDI;
      6'd15:   op_main = OP_ADDIS;
      6'd16:   op_main = OP_BCOND;
      6'd18:   op_main = OP_BR;
      6'd19:   op_main = op19;
      6'd24:   op_main = (in_insn == NOP_WORD) ? OP_NOP : OP_ORI;
      6'd30:   op_main = op30;
      6'd31:   op_main = op31;
      6'd32:   op_main = OP_LOAD;
      6'd36:   op_main = OP_STORE;
      default: op_main = OP_ILL;
    endcase
  end

  assign op_next = op_main;

  // R12
  always_comb begin
    case (op_next)
      OP_ILL, OP_NOP, OP_BR, OP_BCOND, OP_BCREG, OP_CRFLD, OP_SYNC: deps_next = 1'b0;
      default: deps_next = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_op       <= OP_NOP;
      out_illegal  <= 1'b0;
      out_insn     <= '0;
      out_gpr_deps <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_op       <= op_next;
        out_illegal  <= (op_next == OP_ILL);
        out_insn     <= in_insn;
        out_gpr_deps <= deps_next;
      end
    end
  end

endmodule

// File: rtl/insn_decode_2lvl_chk.sv
module insn_decode_2lvl_chk #(
  parameter int OPW = 6
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [31:0]    in_insn,
  input logic           out_valid,
  input logic [OPW-1:0] out_op,
  input logic           out_illegal,
  input logic [31:0]    out_insn,
  input logic           out_gpr_deps
);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r2_valid_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_op) && $stable(out_insn) && $stable(out_illegal) && $stable(out_gpr_deps)));

  a_r2_pass_insn: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_insn == $past(in_insn)));

  a_r11_illegal_code: assert property (@(posedge clk) disable iff (rst)
    out_illegal == (out_op == '0));

  a_r11_illegal_nodeps: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> !out_gpr_deps);

  a_r3_major_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_insn[31:26] == 6'd0) |=> out_illegal);

  a_r4_nop_nodeps: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_insn == 32'h6000_0000) |=> (out_op == 1 && !out_gpr_deps));

endmodule

bind insn_decode_2lvl insn_decode_2lvl_chk #(.OPW(OPW)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn),
  .out_valid(out_valid), .out_op(out_op), .out_illegal(out_illegal),
  .out_insn(out_insn), .out_gpr_deps(out_gpr_deps)
);

// File: tb/insn_decode_2lvl_tb_top.sv
`timescale 1ns/1ps
module insn_decode_2lvl_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_insn = '0;
  logic        out_valid;
  logic [5:0]  out_op;
  logic        out_illegal;
  logic [31:0] out_insn;
  logic        out_gpr_deps;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  insn_decode_2lvl dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn),
    .out_valid(out_valid), .out_op(out_op), .out_illegal(out_illegal),
    .out_insn(out_insn), .out_gpr_deps(out_gpr_deps)
  );

  // {insn, op, illegal, deps, requirement}
  localparam int NV = 47;
  localparam logic [43:0] VEC [NV] = '{
    {32'h3860_0001, 6'd2,  1'b0, 1'b1, 4'd3},  // R3 addi
    {32'h3C20_0010, 6'd3,  1'b0, 1'b1, 4'd3},  // R3 addis
    {32'h4082_0008, 6'd6,  1'b0, 1'b0, 4'd3},  // R3 cond branch
    {32'h4800_0010, 6'd5,  1'b0, 1'b0, 4'd3},  // R3 branch
    {32'h8001_0000, 6'd23, 1'b0, 1'b1, 4'd3},  // R3 load
    {32'h9001_0000, 6'd24, 1'b0, 1'b1, 4'd3},  // R3 store
    {32'h0000_0000, 6'd0,  1'b1, 1'b0, 4'd11}, // R11 major 0
    {32'h0400_0000, 6'd0,  1'b1, 1'b0, 4'd11}, // R11 major 1
    {32'hFC00_0000, 6'd0,  1'b1, 1'b0, 4'd11}, // R11 major 63
    {32'h6000_0000, 6'd1,  1'b0, 1'b0, 4'd4},  // R4 nop
    {32'h6063_0005, 6'd4,  1'b0, 1'b1, 4'd4},  // R4 ori
    {32'h6000_0001, 6'd4,  1'b0, 1'b1, 4'd4},  // R4 near nop
    {32'h4C00_0000, 6'd8,  1'b0, 1'b0, 4'd6},  // R6 minor 0
    {32'h4C00_0202, 6'd8,  1'b0, 1'b0, 4'd6},  // R6 minor 257
    {32'h4C00_0042, 6'd8,  1'b0, 1'b0, 4'd6},  // R6 minor 33
    {32'h4C00_0102, 6'd8,  1'b0, 1'b0, 4'd6},  // R6 minor 129
    {32'h4C00_0182, 6'd8,  1'b0, 1'b0, 4'd6},  // R6 minor 193
    {32'h4C00_01C2, 6'd8,  1'b0, 1'b0, 4'd6},  // R6 minor 225
    {32'h4C00_0242, 6'd8,  1'b0, 1'b0, 4'd6},  // R6 minor 289
    {32'h4C00_0342, 6'd8,  1'b0, 1'b0, 4'd6},  // R6 minor 417
    {32'h4C00_0382, 6'd8,  1'b0, 1'b0, 4'd6},  // R6 minor 449
    {32'h4E80_0020, 6'd7,  1'b0, 1'b0, 4'd6},  // R6 minor 16
    {32'h4E80_0420, 6'd7,  1'b0, 1'b0, 4'd6},  // R6 minor 528
    {32'h4C00_0460, 6'd7,  1'b0, 1'b0, 4'd6},  // R6 minor 560
    {32'h4C00_012C, 6'd9,  1'b0, 1'b0, 4'd6},  // R6 minor 150
    {32'h4C00_0002, 6'd0,  1'b1, 1'b0, 4'd5},  // R5 minor 1, column 0
    {32'h4C00_0028, 6'd0,  1'b1, 1'b0, 4'd5},  // R5 minor 20
    {32'h4C00_0060, 6'd0,  1'b1, 1'b0, 4'd5},  // R5 minor 48, column 4
    {32'h7863_0020, 6'd10, 1'b0, 1'b1, 4'd7},  // R7 idx 0
    {32'h7800_0004, 6'd11, 1'b0, 1'b1, 4'd7},  // R7 idx 1
    {32'h7800_0008, 6'd12, 1'b0, 1'b1, 4'd7},  // R7 idx 2
    {32'h7800_000C, 6'd13, 1'b0, 1'b1, 4'd7},  // R7 idx 3
    {32'h7800_0010, 6'd14, 1'b0, 1'b1, 4'd7},  // R7 idx 4, bit1=0
    {32'h7800_0012, 6'd14, 1'b0, 1'b1, 4'd7},  // R7 idx 4, bit1=1
    {32'h7800_0014, 6'd0,  1'b1, 1'b0, 4'd7},  // R7 idx 5
    {32'h7800_001C, 6'd0,  1'b1, 1'b0, 4'd7},  // R7 idx 7
    {32'h7C63_2214, 6'd15, 1'b0, 1'b1, 4'd8},  // R8 add
    {32'h7C00_0378, 6'd16, 1'b0, 1'b1, 4'd8},  // R8 or
    {32'h7C00_0038, 6'd17, 1'b0, 1'b1, 4'd8},  // R8 and
    {32'h7FE0_0008, 6'd22, 1'b0, 1'b1, 4'd8},  // R8 trap
    {32'h7C00_07FE, 6'd0,  1'b1, 1'b0, 4'd8},  // R8 minor 1023
    {32'h7C60_0026, 6'd18, 1'b0, 1'b1, 4'd9},  // R9 bit20=0
    {32'h7C70_0026, 6'd18, 1'b0, 1'b1, 4'd9},  // R9 bit20=1
    {32'h7C6F_F120, 6'd19, 1'b0, 1'b1, 4'd9},  // R9 bit20=0
    {32'h7C7F_F120, 6'd19, 1'b0, 1'b1, 4'd9},  // R9 bit20=1
    {32'h7C08_02A6, 6'd20, 1'b0, 1'b1, 4'd10}, // R10 spr 8
    {32'h7C10_43A6, 6'd21, 1'b0, 1'b1, 4'd10}  // R10 spr 272
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_rec(input string req, input logic [31:0] insn, input logic [5:0] op,
                           input logic ill, input logic deps);
    check(req, {out_valid, out_insn, out_op, out_illegal, out_gpr_deps},
               {1'b1, insn, op, ill, deps});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {out_valid, out_op, out_illegal, out_insn, out_gpr_deps}, {1'b0, 6'd1, 1'b0, 32'h0, 1'b0});
    rst = 1'b0;
    @(negedge clk);
    check("R1", {out_valid, out_op, out_illegal, out_insn, out_gpr_deps}, {1'b0, 6'd1, 1'b0, 32'h0, 1'b0});

    for (int i = 0; i < NV; i++) begin
      in_valid = 1'b1;
      in_insn  = VEC[i][43:12];
      @(negedge clk);
      check_rec($sformatf("R%0d vec%0d", VEC[i][3:0], i), VEC[i][43:12], VEC[i][11:6], VEC[i][5], VEC[i][4]);
    end

    // R2 hold while idle, input word changing
    held = VEC[NV-1][43:12];
    in_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      in_insn = 32'h0400_0000 + k;
      @(negedge clk);
      check("R2 hold", {out_valid, out_insn, out_op, out_illegal, out_gpr_deps},
                       {1'b0, held, 6'd21, 1'b0, 1'b1});
    end

    // R2 single-cycle update after idle, then R11 pass-through of illegal word
    in_valid = 1'b1;
    in_insn  = 32'h1234_5678;
    @(negedge clk);
    check_rec("R11", 32'h1234_5678, 6'd0, 1'b1, 1'b0);
    in_valid = 1'b0;
    @(negedge clk);
    check("R2 valid drop", {out_valid, out_insn}, {1'b0, 32'h1234_5678});

    // R1 mid-run reset
    in_valid = 1'b1;
    in_insn  = 32'h3860_0001;
    rst = 1'b1;
    @(negedge clk);
    check("R1 rerst", {out_valid, out_op, out_illegal, out_insn, out_gpr_deps}, {1'b0, 6'd1, 1'b0, 32'h0, 1'b0});
    rst = 1'b0;
    @(negedge clk);
    check_rec("R3 after reset", 32'h3860_0001, 6'd2, 1'b0, 1'b1);
    in_valid = 1'b0;
    @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule